// File: doc/BRIEF.md
# Burst Read Buffer with Disconnect Resume

This block sits between a fast local system bus and a simplified PCI-style initiator port and carries local read requests across. A request is either a single 64-bit beat or a four-beat, 32-byte line burst. The PCI side moves 32-bit data phases, so each 64-bit beat takes two phases, low half first. Returned data is gathered into a four-entry line buffer, and the local address phase stays open until every requested beat has landed. The local side then reads the result out through a registered read port.

A target may disconnect in the middle of a burst. The block then asks for the bus again and, once granted, starts a fresh transaction at the first 64-bit beat it does not yet hold. A half-received beat is dropped and fetched again. If another master raises an inbound request while the block waits for that re-grant, the local read is answered with a retry and its partial data is abandoned. This keeps the local burst atomic. An abort from the target or master side ends the read with an error response.

Bursts that begin at a non-zero beat of the line are issued in cache-line-wrap mode, so the target delivers the critical word first. Requests are handled one at a time in the order they arrive.

Top module: `rdbuf_bridge`

## Requirements
- R1: After reset `l_ack`, `l_retry`, `l_err`, `p_req` and `p_start` are all low.
- R2: A memory burst fills all four buffer slots, and the beat at byte address A is stored in slot A[4:3]. `rd_data` presents slot `rd_idx` one cycle after `rd_idx` is applied, with the second data phase in bits 63:32 and the first in bits 31:0.
- R3: A single-beat read takes exactly two 32-bit data phases and fills only slot A[4:3].
- R4: `l_ack` is a one-cycle pulse in the cycle after the final required data phase is sampled. It is never high earlier in the read.
- R5: `lreq_kind` encodes 00 memory, 01 I/O, 10 configuration and 11 interrupt acknowledge, and `p_cmd` carries it with each `p_start`. Only kind 00 with `lreq_burst` high is treated as a burst; every other request is a single beat.
- R6: With each `p_start` pulse, `p_addr` equals the line base plus 8 times the slot of the first beat requested. `p_mode` is 2'b10 (wrap) when the read is a burst and that slot is non-zero, and 2'b00 otherwise.
- R7: After `p_disc`, while beats are still missing, the block keeps `p_req` high and restarts at the first missing beat. The slot counts onward from the original start slot modulo 4, and a half-received beat is requested again.
- R8: When an `in_req` is sampled while the block waits for a re-grant after a disconnect, `l_retry` pulses for one cycle, `p_req` drops and no `l_ack` follows. When `in_req` is sampled at any other time, it has no effect.
- R9: When `p_abort` is sampled during a transfer, `l_err` pulses for one cycle, `p_req` drops and no `l_ack` follows.
- R10: `p_req` stays high from acceptance until `l_ack`, `l_retry` or `l_err`. At most one of these three is high in any cycle, and `p_start` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_valid | input | 1 | Local read request, held until answered |
| lreq_addr | input | AW | Local byte address |
| lreq_kind | input | 2 | Request kind (00 mem, 01 I/O, 10 cfg, 11 int-ack) |
| lreq_burst | input | 1 | Four-beat burst request |
| l_ack | output | 1 | Read complete, buffer valid |
| l_retry | output | 1 | Read abandoned; the local master must retry |
| l_err | output | 1 | Read ended by an abort |
| rd_idx | input | BW | Buffer slot to read |
| rd_data | output | 2*DW | Buffer slot contents, one cycle latency |
| in_req | input | 1 | Inbound request from another master |
| p_req | output | 1 | PCI bus request |
| p_gnt | input | 1 | PCI bus grant |
| p_start | output | 1 | Address phase pulse |
| p_addr | output | AW | Transaction start address |
| p_cmd | output | 2 | Request kind passed to the PCI side |
| p_mode | output | 2 | Burst ordering: 00 linear, 10 line wrap |
| p_dvalid | input | 1 | Data phase valid |
| p_data | input | DW | Data phase value |
| p_disc | input | 1 | Target disconnect, ending the current transaction |
| p_abort | input | 1 | Target or master abort |

## Verification
All results are registered, so each one is due exactly one edge after its cause. `p_start` appears two edges after `lreq_valid` with grant held, `l_ack` follows the edge that samples the last data phase, `l_retry` follows the first waiting cycle in which `in_req` is sampled, and `rd_data` follows the edge that samples `rd_idx`. The bench drives every input on the falling edge and reads outputs on the next falling edge. It therefore checks each result at exactly its due edge, and checks that `l_ack` is still low one edge before it is due. Expected addresses, modes and buffer contents are derived arithmetically from the start slot and the count of beats already received.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
  typedef enum logic [1:0] {
    KIND_MEM  = 2'b00,
    KIND_IO   = 2'b01,
    KIND_CFG  = 2'b10,
    KIND_IACK = 2'b11
  } req_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ARB  = 2'b01,
    ST_XFER = 2'b10
  } rd_state_t;

  localparam logic [1:0] MODE_LINEAR = 2'b00;
  localparam logic [1:0] MODE_WRAP   = 2'b10;
endpackage

// File: rtl/rdb_linebuf.sv
module rdb_linebuf #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 64,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/rdb_addrgen.sv
module rdb_addrgen import rdb_pkg::*; #(
  parameter int AW   = 32,
  parameter int BW   = 2,
  parameter int BOFF = 3,
  localparam int LINE_W = AW - BW - BOFF
) (
  input  logic [LINE_W-1:0] line,
  input  logic [BW-1:0]     slot,
  input  logic              burst,
  output logic [AW-1:0]     addr,
  output logic [1:0]        mode
);
  always_comb begin
    addr = {line, slot, {BOFF{1'b0}}};
    mode = (burst && (slot != '0)) ? MODE_WRAP : MODE_LINEAR;
  end
endmodule

// File: rtl/rdbuf_bridge.sv
module rdbuf_bridge import rdb_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4,
  localparam int BW     = $clog2(BEATS),
  localparam int LW     = 2 * DW,
  localparam int BOFF   = $clog2(LW / 8),
  localparam int OFF    = BW + BOFF,
  localparam int LINE_W = AW - OFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lreq_valid,
  input  logic [AW-1:0] lreq_addr,
  input  logic [1:0]    lreq_kind,
  input  logic          lreq_burst,
  output logic          l_ack,
  output logic          l_retry,
  output logic          l_err,
  input  logic [BW-1:0] rd_idx,
  output logic [LW-1:0] rd_data,
  input  logic          in_req,
  output logic          p_req,
  input  logic          p_gnt,
  output logic          p_start,
  output logic [AW-1:0] p_addr,
  output logic [1:0]    p_cmd,
  output logic [1:0]    p_mode,
  input  logic          p_dvalid,
  input  logic [DW-1:0] p_data,
  input  logic          p_disc,
  input  logic          p_abort
);
  rd_state_t         st;
  logic [LINE_W-1:0] line_q;
  logic [BW-1:0]     s0_q;
  logic [BW:0]       nb_q;
  logic [BW:0]       k_q;
  logic              half_q;
  logic [DW-1:0]     lo_q;
  logic              burst_q;
  logic [1:0]        kind_q;
  logic              resumed_q;

  logic [BW-1:0]     slot;
  logic              last_beat;
  logic              wr_en;
  logic [AW-1:0]     ag_addr;
  logic [1:0]        ag_mode;
  logic              new_burst;

  assign slot      = s0_q + k_q[BW-1:0];
  assign last_beat = ((k_q + 1'b1) == nb_q);
  assign wr_en     = (st == ST_XFER) && !p_abort && p_dvalid && half_q;
  assign p_req     = (st != ST_IDLE);
  assign new_burst = lreq_burst && (lreq_kind == KIND_MEM);

  rdb_addrgen #(.AW(AW), .BW(BW), .BOFF(BOFF)) u_ag (
    .line  (line_q),
    .slot  (slot),
    .burst (burst_q),
    .addr  (ag_addr),
    .mode  (ag_mode)
  );

  rdb_linebuf #(.DEPTH(BEATS), .WIDTH(LW)) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (slot),
    .wr_data ({p_data, lo_q}),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      line_q    <= '0;
      s0_q      <= '0;
      nb_q      <= '0;
      k_q       <= '0;
      half_q    <= 1'b0;
      lo_q      <= '0;
      burst_q   <= 1'b0;
      kind_q    <= KIND_MEM;
      resumed_q <= 1'b0;
      l_ack     <= 1'b0;
      l_retry   <= 1'b0;
      l_err     <= 1'b0;
      p_start   <= 1'b0;
      p_addr    <= '0;
      p_cmd     <= '0;
      p_mode    <= MODE_LINEAR;
    end else begin
      l_ack   <= 1'b0;
      l_retry <= 1'b0;
      l_err   <= 1'b0;
      p_start <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (lreq_valid) begin
            line_q    <= lreq_addr[AW-1:OFF];
            s0_q      <= lreq_addr[OFF-1 -: BW];
            kind_q    <= lreq_kind;
            burst_q   <= new_burst;
            nb_q      <= new_burst ? (BW+1)'(BEATS) : (BW+1)'(1);
            k_q       <= '0;
            half_q    <= 1'b0;
            resumed_q <= 1'b0;
            st        <= ST_ARB;
          end
        end
        ST_ARB: begin
          if (resumed_q && in_req) begin
            l_retry <= 1'b1;
            st      <= ST_IDLE;
          end else if (p_gnt) begin
            p_start <= 1'b1;
            p_addr  <= ag_addr;
            p_mode  <= ag_mode;
            p_cmd   <= kind_q;
            half_q  <= 1'b0;
            st      <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (p_abort) begin
            l_err <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            if (p_dvalid) begin
              if (!half_q) begin
                lo_q   <= p_data;
                half_q <= 1'b1;
              end else begin
                half_q <= 1'b0;
                k_q    <= k_q + 1'b1;
                if (last_beat) begin
                  l_ack <= 1'b1;
                  st    <= ST_IDLE;
                end
              end
            end
            if (p_disc && !(p_dvalid && half_q && last_beat)) begin
              half_q    <= 1'b0;
              resumed_q <= 1'b1;
              st        <= ST_ARB;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: completion responses never overlap
  a_r10_one_response: assert property (@(posedge clk) disable iff (rst)
    $onehot0({l_ack, l_retry, l_err}));

  // R10: bus request only released together with a local response
  a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
    $fell(p_req) |-> (l_ack || l_retry || l_err));

  // R10: address phase lasts one cycle
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
    p_start |=> !p_start);

  // R4: acknowledge only directly after a sampled data phase
  a_r4_ack_after_data: assert property (@(posedge clk) disable iff (rst)
    l_ack |-> $past(p_dvalid));

  // R8: a retry is always caused by a sampled inbound request
  a_r8_retry_cause: assert property (@(posedge clk) disable iff (rst)
    l_retry |-> $past(in_req));

  // R9: an error response is always caused by a sampled abort
  a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
    l_err |-> $past(p_abort));

  // R6: non-memory transactions never use wrap ordering
  a_r6_single_linear: assert property (@(posedge clk) disable iff (rst)
    (p_start && (p_cmd != KIND_MEM)) |-> (p_mode == MODE_LINEAR));
endmodule

// File: tb/rdbuf_bridge_test.sv
module rdbuf_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lreq_valid = 1'b0;
  logic [31:0] lreq_addr = '0;
  logic [1:0]  lreq_kind = '0;
  logic        lreq_burst = 1'b0;
  logic        l_ack, l_retry, l_err;
  logic [1:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        in_req = 1'b0;
  logic        p_req;
  logic        p_gnt = 1'b1;
  logic        p_start;
  logic [31:0] p_addr;
  logic [1:0]  p_cmd, p_mode;
  logic        p_dvalid = 1'b0;
  logic [31:0] p_data = '0;
  logic        p_disc = 1'b0;
  logic        p_abort = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rdbuf_bridge uut (
    .clk(clk), .rst(rst), .lreq_valid(lreq_valid), .lreq_addr(lreq_addr),
    .lreq_kind(lreq_kind), .lreq_burst(lreq_burst), .l_ack(l_ack),
    .l_retry(l_retry), .l_err(l_err), .rd_idx(rd_idx), .rd_data(rd_data),
    .in_req(in_req), .p_req(p_req), .p_gnt(p_gnt), .p_start(p_start),
    .p_addr(p_addr), .p_cmd(p_cmd), .p_mode(p_mode), .p_dvalid(p_dvalid),
    .p_data(p_data), .p_disc(p_disc), .p_abort(p_abort)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tdw(input logic [31:0] a, input bit hi);
    logic [31:0] lo;
    lo = {8'h5A, a[23:0]};
    return hi ? ~lo : lo;
  endfunction

  // disc_at / abort_at: index (from 1) of the data phase carrying the event, 0 = none
  task automatic run(input logic [31:0] addr, input bit burst, input logic [1:0] kind,
                     input int disc_at, input bit do_retry, input bit inbound_first,
                     input int abort_at);
    int nb, s0, got, sent;
    bit is_burst;
    logic [31:0] line;
    is_burst = burst && (kind == 2'b00);
    nb   = is_burst ? 4 : 1;
    s0   = int'(addr[4:3]);
    line = {addr[31:5], 5'b0};
    got  = 0;
    sent = 0;
    @(negedge clk);
    lreq_valid = 1'b1; lreq_addr = addr; lreq_kind = kind; lreq_burst = burst;
    in_req = inbound_first;
    forever begin
      int w, k, es;
      w = 0;
      while (!p_start && w < 20) begin
        @(negedge clk);
        w++;
      end
      chk("R10 address phase issued", {63'd0, p_start}, 64'd1);
      if (!p_start) begin
        lreq_valid = 1'b0;
        return;
      end
      chk("R10 p_req held", {63'd0, p_req}, 64'd1);
      in_req = 1'b0;
      k  = got / 2;
      es = (s0 + k) % 4;
      chk("R6 R7 start address", {32'd0, p_addr}, {32'd0, line + 32'(es * 8)});
      chk("R6 wrap mode", {62'd0, p_mode}, (is_burst && es != 0) ? 64'd2 : 64'd0);
      chk("R5 command kind", {62'd0, p_cmd}, {62'd0, kind});
      for (int j = k * 2; j < nb * 2; j++) begin
        logic [31:0] ba;
        sent++;
        if (sent == abort_at) begin
          p_abort = 1'b1;
          @(negedge clk);
          p_abort = 1'b0;
          chk("R9 error pulse", {63'd0, l_err}, 64'd1);
          chk("R9 no ack", {63'd0, l_ack}, 64'd0);
          chk("R9 request dropped", {63'd0, p_req}, 64'd0);
          lreq_valid = 1'b0;
          @(negedge clk);
          return;
        end
        ba = line + 32'(((s0 + j / 2) % 4) * 8);
        p_dvalid = 1'b1;
        p_data   = tdw(ba, (j % 2) == 1);
        p_disc   = (sent == disc_at);
        chk("R4 no early ack", {63'd0, l_ack}, 64'd0);
        @(negedge clk);
        p_dvalid = 1'b0;
        if (p_disc && j != nb * 2 - 1) begin
          p_disc = 1'b0;
          got = j + 1;
          if (do_retry) begin
            p_gnt = 1'b0;
            in_req = 1'b1;
            @(negedge clk);
            chk("R8 retry pulse", {63'd0, l_retry}, 64'd1);
            chk("R8 request dropped", {63'd0, p_req}, 64'd0);
            chk("R8 no ack", {63'd0, l_ack}, 64'd0);
            lreq_valid = 1'b0;
            in_req = 1'b0;
            p_gnt = 1'b1;
            @(negedge clk);
            return;
          end
          break;
        end
        p_disc = 1'b0;
        if (j == nb * 2 - 1) begin
          chk("R4 ack after last phase", {63'd0, l_ack}, 64'd1);
          lreq_valid = 1'b0;
          for (int b = 0; b < nb; b++) begin
            int sl;
            logic [31:0] a2;
            sl = (s0 + b) % 4;
            a2 = line + 32'(sl * 8);
            rd_idx = 2'(sl);
            @(negedge clk);
            chk(is_burst ? "R2 burst slot data" : "R3 single slot data", rd_data,
                {tdw(a2, 1'b1), tdw(a2, 1'b0)});
          end
          chk("R4 ack is one pulse", {63'd0, l_ack}, 64'd0);
          return;
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset ack",   {63'd0, l_ack},   64'd0);
    chk("R1 reset retry", {63'd0, l_retry}, 64'd0);
    chk("R1 reset err",   {63'd0, l_err},   64'd0);
    chk("R1 reset req",   {63'd0, p_req},   64'd0);
    chk("R1 reset start", {63'd0, p_start}, 64'd0);
    // R2 R3 R5 R6: every kind, burst flag and start slot
    for (int kd = 0; kd < 4; kd++)
      for (int bu = 0; bu < 2; bu++)
        for (int s = 0; s < 4; s++)
          run(32'h0012_3400 + 32'(kd * 'h40) + 32'(s * 8), bu[0], 2'(kd), 0, 1'b0, 1'b0, 0);
    // R7: disconnect after every data phase of a burst, every start slot
    for (int s = 0; s < 4; s++)
      for (int d = 1; d < 8; d++)
        run(32'h0045_6700 + 32'(s * 8), 1'b1, 2'b00, d, 1'b0, 1'b0, 0);
    // R7: single beat disconnected after its first half
    run(32'h0000_0a18, 1'b0, 2'b00, 1, 1'b0, 1'b0, 0);
    // R8: inbound request while waiting to resume
    run(32'h0000_2208, 1'b1, 2'b00, 4, 1'b1, 1'b0, 0);
    run(32'h0000_2218, 1'b1, 2'b00, 1, 1'b1, 1'b0, 0);
    // R8: inbound request during the first arbitration has no effect
    run(32'h0000_3310, 1'b1, 2'b00, 0, 1'b0, 1'b1, 0);
    // R9: aborts at the first phase and mid-burst
    run(32'h0000_4400, 1'b1, 2'b00, 0, 1'b0, 1'b0, 1);
    run(32'h0000_4408, 1'b1, 2'b00, 0, 1'b0, 1'b0, 6);
    // follow-up read after the abort still completes
    run(32'h0000_5518, 1'b1, 2'b00, 0, 1'b0, 1'b0, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule